// File: doc/BRIEF.md
# Register Reservation Scoreboard for In-Order Issue

This block decides, cycle by cycle, whether the instruction at the head of a single issue queue may leave it. It holds one reservation flag per architectural register. A register is flagged from the cycle after an instruction that writes it issues, and the flag drops in the cycle after a completion port names that register. The head instruction leaves only when neither source register nor, if it writes, its destination register is flagged. Instructions that follow the head wait behind it, so issue order always equals program order.

Completions are checked before the issue decision in the same cycle. A head that waits only on a register being retired in that cycle therefore leaves at once. When a new issue claims a register that a completion releases in the same cycle, the claim wins. Register 0 is a constant register and is never flagged. A flush drops every flag and suppresses issue for that cycle. The queue, fetch and execution units sit outside the block. The queue pops its head whenever `issue_go` is high.

Top module: `scb_issue_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `resv_bits` is all zero.
- R2: When the head issues with `hd_wr` high and a nonzero `hd_dst`, bit `hd_dst` of `resv_bits` is 1 in the next cycle.
- R3: A completion port with its valid bit high clears the named register's bit in the next cycle. Several ports may each clear a different register in the same cycle.
- R4: The head does not issue while the register named by `hd_src_a` or `hd_src_b` is reserved and no completion in that cycle names it (read-after-write).
- R5: A head with `hd_wr` high does not issue while its destination is reserved and not being completed (write-after-write). A head with `hd_wr` low ignores `hd_dst`, and `hd_dst` sets nothing for it.
- R6: A completion that names a register the head is waiting on lets the head issue in that same cycle.
- R7: When an issue sets a register and a completion names that same register in the same cycle, the register is reserved in the next cycle.
- R8: Register 0 is never reserved. Naming it as a source or as a destination never stalls the head.
- R9: When `flush` is high, `issue_go` is low in that cycle and `resv_bits` is all zero in the next cycle.
- R10: `issue_go` is high exactly when `hd_valid` is high, `flush` is low and no hazard from R4 or R5 holds. In that case it rises in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop every reservation; no issue this cycle |
| hd_valid | input | 1 | Queue head holds an instruction |
| hd_src_a | input | IW | First source register of the head |
| hd_src_b | input | IW | Second source register of the head |
| hd_dst | input | IW | Destination register of the head |
| hd_wr | input | 1 | Head writes `hd_dst` |
| cmp_valid | input | NCMP | Completion port valid bits |
| cmp_reg | input | NCMP*IW | Completion register indices, port i at bits [i*IW +: IW] |
| issue_go | output | 1 | Head issues this cycle (queue pops) |
| resv_bits | output | NREG | Registered reservation flags, bit r for register r |

## Verification
The bench builds the block with 8 registers and 2 completion ports. With only eight registers, random sources, destinations and completions collide often. This makes same-cycle retire-and-issue, double completions, and set-versus-clear on one register frequent rather than rare events. Two ports let both completions land in one cycle, on the same register or on different ones. Directed sequences cover register 0, flush and a non-writing head before a long random phase.

// File: rtl/scb_pkg.sv
package scb_pkg;
  typedef enum logic [1:0] {
    NXT_HOLD  = 2'd0,
    NXT_CLEAR = 2'd1,
    NXT_SET   = 2'd2,
    NXT_WIPE  = 2'd3
  } nxt_sel_e;

  function automatic nxt_sel_e pick_next(input logic wipe, input logic set, input logic clr);
    if (wipe)      return NXT_WIPE;
    else if (set)  return NXT_SET;
    else if (clr)  return NXT_CLEAR;
    else           return NXT_HOLD;
  endfunction
endpackage

// File: rtl/scb_idx_decode.sv
module scb_idx_decode #(
  parameter int NREG      = 32,
  parameter bit SKIP_ZERO = 1'b0,
  localparam int IW       = $clog2(NREG)
) (
  input  logic          en,
  input  logic [IW-1:0] idx,
  output logic [NREG-1:0] hot
);
  for (genvar r = 0; r < NREG; r++) begin : g_dec
    if (SKIP_ZERO && r == 0) begin : g_zero
      assign hot[r] = 1'b0;
    end else begin : g_cmp
      assign hot[r] = en && (idx == IW'(r));
    end
  end
endmodule

// File: rtl/scb_clear_merge.sv
module scb_clear_merge #(
  parameter int NREG = 32,
  parameter int NCMP = 2,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [NCMP-1:0]    cmp_valid,
  input  logic [NCMP*IW-1:0] cmp_reg,
  output logic [NREG-1:0]    clr_mask
);
  logic [NREG-1:0] port_hot [NCMP];

  for (genvar p = 0; p < NCMP; p++) begin : g_port
    scb_idx_decode #(.NREG(NREG), .SKIP_ZERO(1'b0)) u_dec (
      .en (cmp_valid[p]),
      .idx(cmp_reg[p*IW +: IW]),
      .hot(port_hot[p])
    );
  end

  always_comb begin
    clr_mask = '0;
    for (int p = 0; p < NCMP; p++) clr_mask |= port_hot[p];
  end
endmodule

// File: rtl/scb_bit_cell.sv
module scb_bit_cell
  import scb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wipe,
  input  logic set,
  input  logic clr,
  output logic q
);
  nxt_sel_e sel;
  assign sel = pick_next(wipe, set, clr);

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else begin
      unique case (sel)
        NXT_WIPE:  q <= 1'b0;
        NXT_SET:   q <= 1'b1;
        NXT_CLEAR: q <= 1'b0;
        default:   q <= q;
      endcase
    end
  end
endmodule

// File: rtl/scb_hazard.sv
module scb_hazard #(
  parameter int NREG = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [NREG-1:0] busy_eff,
  input  logic [IW-1:0]   src_a,
  input  logic [IW-1:0]   src_b,
  input  logic [IW-1:0]   dst,
  input  logic            wr,
  output logic            raw_hit,
  output logic            waw_hit
);
  assign raw_hit = busy_eff[src_a] | busy_eff[src_b];
  assign waw_hit = wr & busy_eff[dst];
endmodule

// File: rtl/scb_issue_ctrl.sv
module scb_issue_ctrl #(
  parameter int NREG = 32,
  parameter int NCMP = 2,
  localparam int IW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               hd_valid,
  input  logic [IW-1:0]      hd_src_a,
  input  logic [IW-1:0]      hd_src_b,
  input  logic [IW-1:0]      hd_dst,
  input  logic               hd_wr,
  input  logic [NCMP-1:0]    cmp_valid,
  input  logic [NCMP*IW-1:0] cmp_reg,
  output logic               issue_go,
  output logic [NREG-1:0]    resv_bits
);
  logic [NREG-1:0] clr_mask;
  logic [NREG-1:0] set_mask;
  logic [NREG-1:0] busy_eff;
  logic            raw_hit;
  logic            waw_hit;

  scb_clear_merge #(.NREG(NREG), .NCMP(NCMP)) u_clr (
    .cmp_valid(cmp_valid),
    .cmp_reg  (cmp_reg),
    .clr_mask (clr_mask)
  );

  // completions retire before the head is judged
  assign busy_eff = resv_bits & ~clr_mask;

  scb_hazard #(.NREG(NREG)) u_haz (
    .busy_eff(busy_eff),
    .src_a   (hd_src_a),
    .src_b   (hd_src_b),
    .dst     (hd_dst),
    .wr      (hd_wr),
    .raw_hit (raw_hit),
    .waw_hit (waw_hit)
  );

  assign issue_go = hd_valid & ~flush & ~raw_hit & ~waw_hit;

  // register 0 is skipped so it can never be claimed
  scb_idx_decode #(.NREG(NREG), .SKIP_ZERO(1'b1)) u_set (
    .en (issue_go & hd_wr),
    .idx(hd_dst),
    .hot(set_mask)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_cell
    scb_bit_cell u_cell (
      .clk (clk),
      .rst (rst),
      .wipe(flush),
      .set (set_mask[r]),
      .clr (clr_mask[r]),
      .q   (resv_bits[r])
    );
  end
endmodule

// File: rtl/scb_issue_chk.sv
module scb_issue_chk #(
  parameter int NREG = 32,
  parameter int NCMP = 2,
  localparam int IW  = $clog2(NREG)
) (
  input logic               clk,
  input logic               rst,
  input logic               flush,
  input logic               hd_valid,
  input logic [IW-1:0]      hd_src_a,
  input logic [IW-1:0]      hd_src_b,
  input logic [IW-1:0]      hd_dst,
  input logic               hd_wr,
  input logic [NCMP-1:0]    cmp_valid,
  input logic [NCMP*IW-1:0] cmp_reg,
  input logic               issue_go,
  input logic [NREG-1:0]    resv_bits
);
  function automatic logic retiring(input logic [IW-1:0] r);
    logic h = 1'b0;
    for (int p = 0; p < NCMP; p++)
      if (cmp_valid[p] && cmp_reg[p*IW +: IW] == r) h = 1'b1;
    return h;
  endfunction

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> resv_bits == '0);

  assert_set_on_issue_R2: assert property (@(posedge clk) disable iff (rst)
    issue_go && hd_wr && hd_dst != '0 |=> resv_bits[$past(hd_dst)]);

  for (genvar p = 0; p < NCMP; p++) begin : g_clr
    assert_clear_on_done_R3: assert property (@(posedge clk) disable iff (rst)
      cmp_valid[p] && !(issue_go && hd_wr && hd_dst == cmp_reg[p*IW +: IW])
      |=> !resv_bits[$past(cmp_reg[p*IW +: IW])]);
  end

  assert_no_raw_a_R4: assert property (@(posedge clk) disable iff (rst)
    issue_go |-> !resv_bits[hd_src_a] || retiring(hd_src_a));

  assert_no_raw_b_R4: assert property (@(posedge clk) disable iff (rst)
    issue_go |-> !resv_bits[hd_src_b] || retiring(hd_src_b));

  assert_no_waw_R5: assert property (@(posedge clk) disable iff (rst)
    issue_go && hd_wr |-> !resv_bits[hd_dst] || retiring(hd_dst));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    issue_go && hd_wr && hd_dst != '0 && retiring(hd_dst) |=> resv_bits[$past(hd_dst)]);

  assert_zero_free_R8: assert property (@(posedge clk) disable iff (rst) !resv_bits[0]);

  assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (rst) flush |-> !issue_go);

  assert_flush_wipe_R9: assert property (@(posedge clk) disable iff (rst) flush |=> resv_bits == '0);

  assert_needs_head_R10: assert property (@(posedge clk) disable iff (rst) issue_go |-> hd_valid);
endmodule

bind scb_issue_ctrl scb_issue_chk #(.NREG(NREG), .NCMP(NCMP)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .hd_valid(hd_valid),
  .hd_src_a(hd_src_a), .hd_src_b(hd_src_b), .hd_dst(hd_dst), .hd_wr(hd_wr),
  .cmp_valid(cmp_valid), .cmp_reg(cmp_reg),
  .issue_go(issue_go), .resv_bits(resv_bits)
);

// File: tb/sim_scb_issue_ctrl.sv
`timescale 1ns/1ps
module sim_scb_issue_ctrl;
  localparam int NREG = 8;
  localparam int NCMP = 2;
  localparam int IW   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic hd_valid = 1'b0;
  logic [IW-1:0] hd_src_a = '0, hd_src_b = '0, hd_dst = '0;
  logic hd_wr = 1'b0;
  logic [NCMP-1:0] cmp_valid = '0;
  logic [NCMP*IW-1:0] cmp_reg = '0;
  logic issue_go;
  logic [NREG-1:0] resv_bits;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit ref_busy [NREG];

  always #10 clk = ~clk;

  scb_issue_ctrl #(.NREG(NREG), .NCMP(NCMP)) u0 (
    .clk(clk), .rst(rst), .flush(flush), .hd_valid(hd_valid),
    .hd_src_a(hd_src_a), .hd_src_b(hd_src_b), .hd_dst(hd_dst), .hd_wr(hd_wr),
    .cmp_valid(cmp_valid), .cmp_reg(cmp_reg),
    .issue_go(issue_go), .resv_bits(resv_bits)
  );

  function automatic bit retire_hit(int r);
    bit h = 0;
    for (int p = 0; p < NCMP; p++)
      if (cmp_valid[p] && int'(cmp_reg[p*IW +: IW]) == r) h = 1;
    return h;
  endfunction

  function automatic bit eff(int r);
    return ref_busy[r] && !retire_hit(r);
  endfunction

  function automatic logic [NREG-1:0] ref_vec();
    logic [NREG-1:0] v;
    for (int r = 0; r < NREG; r++) v[r] = ref_busy[r];
    return v;
  endfunction

  task automatic check(string tag, bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // one cycle: inputs already set after the falling edge
  task automatic step(string tag);
    bit exp_go;
    logic [NREG-1:0] rv;
    #8;
    exp_go = hd_valid && !flush && !eff(int'(hd_src_a)) && !eff(int'(hd_src_b))
             && !(hd_wr && eff(int'(hd_dst)));
    rv = ref_vec();
    check(tag, issue_go, exp_go, "issue_go");
    checks++;
    if (resv_bits !== rv) begin
      fails++;
      $display("FAIL %s resv_bits actual %b expected %b", tag, resv_bits, rv);
    end
    @(posedge clk);
    for (int r = 0; r < NREG; r++) begin
      if (flush) ref_busy[r] = 0;
      else if (exp_go && hd_wr && r != 0 && int'(hd_dst) == r) ref_busy[r] = 1;
      else if (retire_hit(r)) ref_busy[r] = 0;
    end
    @(negedge clk);
  endtask

  task automatic drive(bit v, int a, int b, int d, bit w,
                       bit c0v, int c0r, bit c1v, int c1r, bit fl);
    hd_valid = v; hd_src_a = IW'(a); hd_src_b = IW'(b); hd_dst = IW'(d); hd_wr = w;
    cmp_valid = {c1v, c0v}; cmp_reg = {IW'(c1r), IW'(c0r)}; flush = fl;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NREG; r++) ref_busy[r] = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (resv_bits !== '0) begin fails++; $display("FAIL R1 resv_bits actual %b expected 0", resv_bits); end
    rst = 1'b0;
    idle(); step("R1");
    // R2: writer to r3 issues and claims it
    drive(1, 1, 2, 3, 1, 0, 0, 0, 0, 0); step("R2");
    idle(); step("R2");
    // R4: reader of r3 stalls, on both source slots
    drive(1, 3, 1, 4, 1, 0, 0, 0, 0, 0); step("R4");
    drive(1, 2, 3, 4, 1, 0, 0, 0, 0, 0); step("R4");
    // R5: writer of r3 stalls; non-writer with dst r3 goes and sets nothing
    drive(1, 1, 2, 3, 1, 0, 0, 0, 0, 0); step("R5");
    drive(1, 1, 2, 3, 0, 0, 0, 0, 0, 0); step("R5");
    idle(); step("R5");
    // R6: completion of r3 lets the reader issue at once
    drive(1, 3, 1, 6, 0, 1, 3, 0, 0, 0); step("R6");
    idle(); step("R6");
    // R7: claim r5, then reissue on r5 while it retires
    drive(1, 0, 0, 5, 1, 0, 0, 0, 0, 0); step("R7");
    drive(1, 0, 0, 5, 1, 0, 0, 1, 5, 0); step("R7");
    idle(); step("R7");
    // R8: writes to r0 never reserve it, reads of r0 never stall
    drive(1, 0, 0, 0, 1, 0, 0, 0, 0, 0); step("R8");
    drive(1, 0, 0, 0, 1, 0, 0, 0, 0, 0); step("R8");
    // R3: two ports clear two registers together
    drive(1, 1, 1, 2, 1, 0, 0, 0, 0, 0); step("R3");
    drive(1, 1, 1, 4, 1, 1, 5, 0, 0, 0); step("R3");
    drive(0, 0, 0, 0, 0, 1, 2, 1, 4, 0); step("R3");
    idle(); step("R3");
    // R9: flush wipes and blocks a clean head
    drive(1, 1, 1, 6, 1, 0, 0, 0, 0, 0); step("R9");
    drive(1, 1, 1, 7, 1, 0, 0, 0, 0, 1); step("R9");
    idle(); step("R9");
    // R10: no head, no issue
    drive(0, 1, 1, 2, 1, 0, 0, 0, 0, 0); step("R10");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      drive($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 7),
            $urandom_range(0, 7), $urandom_range(0, 1),
            $urandom_range(0, 2) == 0, $urandom_range(0, 7),
            $urandom_range(0, 2) == 0, $urandom_range(0, 7),
            $urandom_range(0, 60) == 0);
      step("R10");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule